// File: doc/BRIEF.md
# Multi-Mode 16-bit Down Timer

This block is a 16-bit down counter that one timer engine shares among three ways of working. In periodic mode it decrements once per instruction-cycle enable. When it passes zero it reloads from a reload register, flips a square-wave output and raises a pending flag. In event mode the same counter decrements on each chosen edge of an external pin instead. In capture mode the counter runs on the cycle enable, and the chosen pin edge copies the running value into a capture register. In that mode the capture, and not the underflow, raises the pending flag.

Software reaches the block through one write port. `wr_sel` picks the count register, the reload register or the control word. A small state machine turns the run bit and the mode field into one of four states: `ST_STOP`, `ST_RELOAD`, `ST_EVENT` and `ST_CAPT`. The state register moves only on a cycle-enable pulse. The possible transitions are these:
- From `ST_STOP` to a running state, when run is set and the mode is valid.
- From any running state to another running state, when the mode field changes.
- From any state back to `ST_STOP`, when run is cleared or the reserved mode is selected.

The external pin passes through a two-flop synchronizer and an edge detector. The detector picks the rising or falling edge.

Top module: `dtmr_top`

## Requirements
- R1: After reset, `count_o`, `capture_o`, the reload register, `tog_o`, `pend_o` and `irq_o` are all 0, and the timer is stopped.
- R2: `wr_sel` selects the write target: 0 writes the count, 1 writes the reload and 2 writes the control word. The control bits are: [1:0] mode (0 periodic, 1 event, 2 capture, 3 reserved = stopped), [2] run, [3] edge (0 rising, 1 falling), [4] interrupt enable, [5] clear pending. While the timer is stopped, a count write loads `count_o` on the next clock and the count otherwise holds.
- R3: In periodic mode, each cycle-enable decrements the count. A cycle-enable that finds the count at 0 loads the reload value, inverts `tog_o` and sets `pend_o`.
- R4: In event mode, the count decrements once per selected edge of `ext_in` and ignores the cycle enable. An edge that finds the count at 0 reloads it and sets `pend_o`. `tog_o` does not change in this mode.
- R5: In capture mode, the count decrements on the cycle enable and reloads at zero without setting `pend_o`. A selected edge of `ext_in` copies the current count into `capture_o` and sets `pend_o`.
- R6: The edge bit selects the active edge of `ext_in`: 0 selects rising and 1 selects falling. The opposite edge has no effect.
- R7: A change of mode or run bit takes effect at the next cycle-enable clock edge. Until then the previous state's behaviour applies.
- R8: A count write while the timer is running is ignored.
- R9: Writing the control word with bit 5 set clears `pend_o`. If a setting event occurs in the same cycle, `pend_o` stays 1.
- R10: `irq_o` is 1 only when `pend_o` is 1 and the interrupt enable is 1.
- R11: Suppose a level change on `ext_in` is first sampled at clock edge k. The count or capture update it causes happens at edge k+2 and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | Instruction-cycle enable pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 count, 1 reload, 2 control |
| wr_data | input | 16 | Write data |
| ext_in | input | 1 | External event / capture pin |
| count_o | output | 16 | Current count |
| capture_o | output | 16 | Captured count |
| tog_o | output | 1 | Square wave, inverted on each periodic underflow |
| pend_o | output | 1 | Timer pending flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bound checker watches several properties on every cycle:
- A stopped timer's count changes only through a count write.
- `tog_o` changes only on a periodic underflow.
- A periodic decrement is exactly one.
- `capture_o` moves only in capture mode.
- `pend_o` survives any cycle without a clear, and the interrupt stays low while it is disabled.

Some behaviours can only be shown by the directed scenarios:
- The exact reload values.
- The one-enable lag of a mode change.
- The two-clock synchronizer latency.
- Edge polarity.
- The precedence of a set over a clear that land in the same cycle.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
    typedef enum logic [1:0] {
        MODE_RELOAD = 2'd0,
        MODE_EVENT  = 2'd1,
        MODE_CAPT   = 2'd2,
        MODE_RSVD   = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ST_STOP   = 2'd0,
        ST_RELOAD = 2'd1,
        ST_EVENT  = 2'd2,
        ST_CAPT   = 2'd3
    } tstate_e;

    localparam logic [1:0] SEL_COUNT  = 2'd0;
    localparam logic [1:0] SEL_RELOAD = 2'd1;
    localparam logic [1:0] SEL_CTRL   = 2'd2;

    localparam int CTRL_BITS = 6;
    localparam int CLR_BIT   = 5;

    typedef struct packed {
        logic  clr;
        logic  ie;
        logic  fall;
        logic  run;
        mode_e mode;
    } ctrl_t;
endpackage

// File: rtl/dtmr_edge.sv
module dtmr_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic fall_i,
    output logic edge_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cur;

    assign cur = sync_q[SYNC_STAGES-1];

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= cur;
    end

    assign edge_o = fall_i ? (prev_q & ~cur) : (cur & ~prev_q);
endmodule

// File: rtl/dtmr_fsm.sv
module dtmr_fsm
    import dtmr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cyc_en_i,
    input  logic    run_i,
    input  mode_e   mode_i,
    output tstate_e state_o
);
    tstate_e state_q;
    tstate_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)        state_q <= ST_STOP;
        else if (cyc_en_i) state_q <= state_d;
    end

    always_comb begin
        state_d = ST_STOP;
        if (run_i) begin
            unique case (mode_i)
                MODE_RELOAD: state_d = ST_RELOAD;
                MODE_EVENT:  state_d = ST_EVENT;
                MODE_CAPT:   state_d = ST_CAPT;
                MODE_RSVD:   state_d = ST_STOP;
            endcase
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/dtmr_core.sv
module dtmr_core
    import dtmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  tstate_e      state_i,
    input  logic         cyc_en_i,
    input  logic         edge_i,
    input  logic         cnt_wr_i,
    input  logic         rld_wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] cap_o,
    output logic         tog_o,
    output logic         set_o
);
    logic [W-1:0] cnt_q, cnt_d;
    logic [W-1:0] rld_q;
    logic [W-1:0] cap_q, cap_d;
    logic         tog_q, tog_d;
    logic         at_zero;

    assign at_zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rld_q <= '0;
            cap_q <= '0;
            tog_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            cap_q <= cap_d;
            tog_q <= tog_d;
            if (rld_wr_i) rld_q <= wdata_i;
        end
    end

    always_comb begin
        cnt_d = cnt_q;
        cap_d = cap_q;
        tog_d = tog_q;
        set_o = 1'b0;
        unique case (state_i)
            ST_STOP: begin
                if (cnt_wr_i) cnt_d = wdata_i;
            end
            ST_RELOAD: begin
                if (cyc_en_i) begin
                    if (at_zero) begin
                        cnt_d = rld_q;
                        tog_d = ~tog_q;
                        set_o = 1'b1;
                    end else begin
                        cnt_d = cnt_q - W'(1);
                    end
                end
            end
            ST_EVENT: begin
                if (edge_i) begin
                    if (at_zero) begin
                        cnt_d = rld_q;
                        set_o = 1'b1;
                    end else begin
                        cnt_d = cnt_q - W'(1);
                    end
                end
            end
            ST_CAPT: begin
                if (cyc_en_i) cnt_d = at_zero ? rld_q : cnt_q - W'(1);
                if (edge_i) begin
                    cap_d = cnt_q;
                    set_o = 1'b1;
                end
            end
        endcase
    end

    assign cnt_o = cnt_q;
    assign cap_o = cap_q;
    assign tog_o = tog_q;
endmodule

// File: rtl/dtmr_top.sv
module dtmr_top
    import dtmr_pkg::*;
#(
    parameter int W = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cyc_en,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         ext_in,
    output logic [W-1:0] count_o,
    output logic [W-1:0] capture_o,
    output logic         tog_o,
    output logic         pend_o,
    output logic         irq_o
);
    ctrl_t   ctrl_q;
    ctrl_t   ctrl_wr;
    tstate_e state;
    logic    ext_edge;
    logic    pend_set;
    logic    pend_clr;
    logic    ctrl_we;
    logic    ctrl_ie;
    logic    pend_q;

    assign ctrl_wr  = ctrl_t'(wr_data[CTRL_BITS-1:0]);
    assign ctrl_we  = wr_en && (wr_sel == SEL_CTRL);
    assign pend_clr = ctrl_we && wr_data[CLR_BIT];
    assign ctrl_ie  = ctrl_q.ie;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q     <= ctrl_wr;
            ctrl_q.clr <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (pend_set) pend_q <= 1'b1;
        else if (pend_clr) pend_q <= 1'b0;
    end

    dtmr_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_in),
        .fall_i (ctrl_q.fall),
        .edge_o (ext_edge)
    );

    dtmr_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_en_i (cyc_en),
        .run_i    (ctrl_q.run),
        .mode_i   (ctrl_q.mode),
        .state_o  (state)
    );

    dtmr_core #(.W(W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_i  (state),
        .cyc_en_i (cyc_en),
        .edge_i   (ext_edge),
        .cnt_wr_i (wr_en && (wr_sel == SEL_COUNT)),
        .rld_wr_i (wr_en && (wr_sel == SEL_RELOAD)),
        .wdata_i  (wr_data),
        .cnt_o    (count_o),
        .cap_o    (capture_o),
        .tog_o    (tog_o),
        .set_o    (pend_set)
    );

    assign pend_o = pend_q;
    assign irq_o  = pend_q & ctrl_ie;
endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chk
    import dtmr_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cyc_en,
    input logic         wr_en,
    input logic [1:0]   wr_sel,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] count_o,
    input logic [W-1:0] capture_o,
    input logic         tog_o,
    input logic         pend_o,
    input logic         irq_o,
    input tstate_e      state,
    input logic         ie
);
    logic cnt_wr;
    logic clr_wr;

    assign cnt_wr = wr_en && (wr_sel == SEL_COUNT);
    assign clr_wr = wr_en && (wr_sel == SEL_CTRL) && wr_data[CLR_BIT];

    assert_stop_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && !cnt_wr) |=> $stable(count_o));

    assert_tog_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(state == ST_RELOAD && cyc_en && count_o == '0) |=> $stable(tog_o));

    assert_dec_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RELOAD && cyc_en && count_o != '0) |=> (count_o == $past(count_o) - W'(1)));

    assert_capture_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_CAPT) |=> $stable(capture_o));

    assert_pend_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_wr) |=> pend_o);

    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie || !pend_o) |-> !irq_o);
endmodule

bind dtmr_top dtmr_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_en    (cyc_en),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .count_o   (count_o),
    .capture_o (capture_o),
    .tog_o     (tog_o),
    .pend_o    (pend_o),
    .irq_o     (irq_o),
    .state     (state),
    .ie        (ctrl_ie)
);

// File: tb/dtmr_top_tb.sv
module dtmr_top_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cyc_en;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [15:0] wr_data;
    logic        ext_in;
    logic [15:0] count_o;
    logic [15:0] capture_o;
    logic        tog_o;
    logic        pend_o;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dtmr_top u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .ext_in(ext_in),
        .count_o(count_o), .capture_o(capture_o), .tog_o(tog_o),
        .pend_o(pend_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] cw(input logic [1:0] mode, input logic run,
                                       input logic fall, input logic ie, input logic clr);
        return {10'd0, clr, ie, fall, run, mode};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; cyc_en = 1'b0; wr_en = 1'b0; wr_sel = 2'd0;
        wr_data = '0; ext_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick(input int n);
        cyc_en = 1'b1;
        repeat (n) @(negedge clk);
        cyc_en = 1'b0;
    endtask

    task automatic ext_set(input logic v);
        ext_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 count", count_o, 0);
        chk("R1 capture", capture_o, 0);
        chk("R1 tog", tog_o, 0);
        chk("R1 pend", pend_o, 0);
        chk("R1 irq", irq_o, 0);
        tick(3);
        chk("R1 stopped after reset", count_o, 0);
    endtask

    task automatic t_stop_load();
        do_reset();
        wr(2'd0, 16'h00A5);
        chk("R2 stopped count write", count_o, 16'h00A5);
        tick(4);
        chk("R2 stopped holds", count_o, 16'h00A5);
        wr(2'd2, cw(2'd3, 1'b1, 1'b0, 1'b0, 1'b0));
        tick(3);
        chk("R2 reserved mode holds", count_o, 16'h00A5);
    endtask

    task automatic t_periodic();
        do_reset();
        wr(2'd0, 16'd3);
        wr(2'd1, 16'd5);
        wr(2'd2, cw(2'd0, 1'b1, 1'b0, 1'b0, 1'b0));
        repeat (3) @(negedge clk);
        chk("R7 no effect before enable", count_o, 3);
        tick(1);
        chk("R7 first enable only switches state", count_o, 3);
        wr(2'd0, 16'h1234);
        chk("R8 running write ignored", count_o, 3);
        tick(3);
        chk("R3 count at zero", count_o, 0);
        chk("R3 no pend before underflow", pend_o, 0);
        tick(1);
        chk("R3 reload", count_o, 5);
        chk("R3 toggle", tog_o, 1);
        chk("R3 pend", pend_o, 1);
        chk("R10 irq off when disabled", irq_o, 0);
        wr(2'd2, cw(2'd0, 1'b1, 1'b0, 1'b1, 1'b0));
        chk("R10 irq on when enabled", irq_o, 1);
        wr(2'd2, cw(2'd0, 1'b1, 1'b0, 1'b1, 1'b1));
        chk("R9 write-one clears", pend_o, 0);
    endtask

    task automatic t_set_wins();
        do_reset();
        wr(2'd1, 16'd4);
        wr(2'd2, cw(2'd0, 1'b1, 1'b0, 1'b0, 1'b0));
        tick(1);
        wr_en = 1'b1; wr_sel = 2'd2; wr_data = cw(2'd0, 1'b1, 1'b0, 1'b0, 1'b1);
        cyc_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; cyc_en = 1'b0;
        chk("R9 set wins over clear", pend_o, 1);
        chk("R3 reload from zero", count_o, 4);
    endtask

    task automatic t_event();
        do_reset();
        wr(2'd0, 16'd2);
        wr(2'd1, 16'd7);
        wr(2'd2, cw(2'd1, 1'b1, 1'b0, 1'b0, 1'b0));
        tick(1);
        tick(5);
        chk("R4 cycle enable ignored", count_o, 2);
        ext_in = 1'b1;
        @(negedge clk);
        chk("R11 not at edge k", count_o, 2);
        @(negedge clk);
        chk("R11 not at edge k+1", count_o, 2);
        @(negedge clk);
        chk("R11 update at edge k+2", count_o, 1);
        @(negedge clk);
        ext_set(1'b0);
        chk("R4 falling edge no count", count_o, 1);
        ext_set(1'b1);
        ext_set(1'b0);
        chk("R4 second edge", count_o, 0);
        ext_set(1'b1);
        chk("R4 reload on underflow", count_o, 7);
        chk("R4 pend", pend_o, 1);
        chk("R4 no toggle", tog_o, 0);
    endtask

    task automatic t_capture();
        do_reset();
        wr(2'd0, 16'd10);
        wr(2'd1, 16'd20);
        wr(2'd2, cw(2'd2, 1'b1, 1'b0, 1'b1, 1'b0));
        tick(1);
        chk("R7 entered capture", count_o, 10);
        ext_set(1'b1);
        chk("R5 captured", capture_o, 10);
        chk("R5 pend", pend_o, 1);
        chk("R10 irq", irq_o, 1);
        tick(3);
        chk("R5 counts on enable", count_o, 7);
        ext_set(1'b0);
        chk("R6 opposite edge ignored", capture_o, 10);
        wr(2'd2, cw(2'd2, 1'b1, 1'b0, 1'b1, 1'b1));
        tick(8);
        chk("R5 underflow reload", count_o, 20);
        chk("R5 underflow no pend", pend_o, 0);
    endtask

    task automatic t_polarity();
        do_reset();
        wr(2'd0, 16'd9);
        wr(2'd2, cw(2'd2, 1'b1, 1'b1, 1'b0, 1'b0));
        tick(1);
        ext_set(1'b1);
        chk("R6 rising ignored when falling set", capture_o, 0);
        chk("R6 no pend on rising", pend_o, 0);
        ext_set(1'b0);
        chk("R6 falling captures", capture_o, 9);
        chk("R6 pend on falling", pend_o, 1);
    endtask

    initial begin
        t_reset();
        t_stop_load();
        t_periodic();
        t_set_wins();
        t_event();
        t_capture();
        t_polarity();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule